// File: doc/BRIEF.md
# Programmable Interrupt Request Output with Assertion Holdoff

This block gathers a bank of latched interrupt events and an enable mask into one interrupt request line for a host processor. Each event source sets its own status bit on a single-cycle pulse. The bit stays set until the host writes a one to it. The request goes active when at least one set status bit is also enabled. After that it stays active until the host has cleared or masked every enabled pending bit.

The output stage can drive the line push-pull, with either active level. It can also emulate an open-drain pad by giving a driven value of zero plus an output-enable. A holdoff timer starts each time the request drops. It counts down on an external 10 µs tick, and no new assertion may happen until it reaches zero. This sets a minimum quiet time between interrupts and so limits how much host time the device can take.

Software reaches three registers through a simple select/write/read port:

- Select 0 is the configuration register. It holds the active-level bit, the drive-type bit and the holdoff count.
- Select 1 is the enable mask. The host changes it with read-modify-write accesses.
- Select 2 is the pending-status register. Writing a one to a bit clears that bit.

Top module: `irq_gen`

## Requirements
- R1: In push-pull mode, configuration bit 0 sets the active level. When it is 1, `irq_o` equals the request. When it is 0, `irq_o` is the inverse of the request.
- R2: Configuration bit 1 sets the drive type: 1 is push-pull and 0 is open-drain. In push-pull mode `irq_oe_o` is always 1.
- R3: In open-drain mode `irq_o` is always 0 and bit 0 has no effect. `irq_oe_o` is 1 only while the request is active.
- R4: A source pulse on `evt_i[i]` sets pending bit i at the next clock edge. The request rises one edge later and stays active as long as an enabled pending bit remains set.
- R5: A pending bit only raises the request while the matching bit of the enable register (select 1) is 1. The enable register reads back the value last written to it.
- R6: Writing to the status register (select 2) clears only the bits written as 1. If a source pulse and a clear for the same bit arrive in the same cycle, the bit stays set. Reading select 2 returns the pending bits.
- R7: Configuration bits [31:24] hold the holdoff count. When the request drops, a timer loads this count. The timer decreases by one at each clock edge where `tick_i` is 1. The request cannot go active again until the timer has reached zero.
- R8: With a holdoff count of 0, an enabled pending bit that is present when the request drops makes the request go active again on the next edge.
- R9: After reset every register reads 0. The line is then in open-drain mode with `irq_o` = 0 and `irq_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every 10 µs |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 config, 1 enable, 2 status |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register (combinational) |
| irq_o | output | 1 | Value driven onto the interrupt line |
| irq_oe_o | output | 1 | Output-enable of the interrupt line |

## Verification
The assertions assume the following about the inputs:
- `tick_i` and the event inputs are synchronous single-cycle pulses.
- The register select is one of the three defined values whenever a write happens.
- The configuration register is not rewritten in the same cycle that the request drops.

The stimulus respects all of this. It drives every input just after a rising edge and pulses each event or tick for exactly one cycle. It changes the configuration only while the request is stable.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      SEL_CFG  = 2'd0,
      SEL_MASK = 2'd1,
      SEL_PEND = 2'd2
   } reg_sel_e;

   localparam int CFG_POL_BIT = 0;
   localparam int CFG_PP_BIT  = 1;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (evt_i[g]) begin
            bit_q <= 1'b1;
         end else if (clr_i[g]) begin
            bit_q <= 1'b0;
         end
      end
      assign pend_o[g] = bit_q;
   end

endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              req_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              act_o,
   output logic [HOLD_W-1:0] cnt_o
);

   logic              act_q;
   logic [HOLD_W-1:0] cnt_q;
   logic              drop;
   logic              rise;
   logic              cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign drop     = act_q & ~req_i;
   assign rise     = ~act_q & req_i & cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else if (drop) begin
         act_q <= 1'b0;
      end else if (rise) begin
         act_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (drop) begin
         cnt_q <= hold_i;
      end else if (tick_i && !cnt_zero) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign act_o = act_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/irq_pad_map.sv
module irq_pad_map (
   input  logic act_i,
   input  logic pp_i,
   input  logic pol_i,
   output logic pin_o,
   output logic oe_o
);

   always_comb begin
      if (pp_i) begin
         oe_o  = 1'b1;
         pin_o = pol_i ? act_i : ~act_i;
      end else begin
         oe_o  = act_i;
         pin_o = 1'b0;
      end
   end

endmodule

// File: rtl/irq_gen.sv
module irq_gen
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int HOLD_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               reg_wr_i,
   input  logic [1:0]         reg_sel_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               irq_o,
   output logic               irq_oe_o
);

   localparam int HOLD_LSB = DATA_W - HOLD_W;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_gen: NUM_SRC must lie in 1..DATA_W");
   end
   if (HOLD_W < 1 || HOLD_W + 2 > DATA_W) begin : g_bad_hold
      $error("irq_gen: HOLD_W leaves no room for the mode bits");
   end

   logic               cfg_pol_q;
   logic               cfg_pp_q;
   logic [HOLD_W-1:0]  cfg_hold_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] pend_w;
   logic [NUM_SRC-1:0] clr_w;
   logic               req_w;
   logic               act_w;
   logic [HOLD_W-1:0]  cnt_w;
   logic               wr_cfg;
   logic               wr_mask;
   logic               wr_pend;

   assign wr_cfg  = reg_wr_i && (reg_sel_i == SEL_CFG);
   assign wr_mask = reg_wr_i && (reg_sel_i == SEL_MASK);
   assign wr_pend = reg_wr_i && (reg_sel_i == SEL_PEND);
   assign clr_w   = wr_pend ? reg_wdata_i[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_pol_q  <= 1'b0;
         cfg_pp_q   <= 1'b0;
         cfg_hold_q <= '0;
      end else if (wr_cfg) begin
         cfg_pol_q  <= reg_wdata_i[CFG_POL_BIT];
         cfg_pp_q   <= reg_wdata_i[CFG_PP_BIT];
         cfg_hold_q <= reg_wdata_i[DATA_W-1:HOLD_LSB];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_mask) begin
         mask_q <= reg_wdata_i[NUM_SRC-1:0];
      end
   end

   irq_status_bank #(.NUM_SRC(NUM_SRC)) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .clr_i  (clr_w),
      .pend_o (pend_w)
   );

   assign req_w = |(pend_w & mask_q);

   irq_holdoff #(.HOLD_W(HOLD_W)) i_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .req_i  (req_w),
      .hold_i (cfg_hold_q),
      .act_o  (act_w),
      .cnt_o  (cnt_w)
   );

   irq_pad_map i_pad (
      .act_i (act_w),
      .pp_i  (cfg_pp_q),
      .pol_i (cfg_pol_q),
      .pin_o (irq_o),
      .oe_o  (irq_oe_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      case (reg_sel_i)
         SEL_CFG: begin
            reg_rdata_o[CFG_POL_BIT]        = cfg_pol_q;
            reg_rdata_o[CFG_PP_BIT]         = cfg_pp_q;
            reg_rdata_o[DATA_W-1:HOLD_LSB]  = cfg_hold_q;
         end
         SEL_MASK: reg_rdata_o[NUM_SRC-1:0] = mask_q;
         SEL_PEND: reg_rdata_o[NUM_SRC-1:0] = pend_w;
         default:  reg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/irq_gen_chk.sv
module irq_gen_chk #(
   parameter int NUM_SRC = 8,
   parameter int HOLD_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pp,
   input logic [HOLD_W-1:0]  hold,
   input logic [NUM_SRC-1:0] evt,
   input logic [NUM_SRC-1:0] clr,
   input logic [NUM_SRC-1:0] pend,
   input logic               req,
   input logic               act,
   input logic [HOLD_W-1:0]  cnt,
   input logic               pin,
   input logic               oe
);

   AST_PP_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      pp |-> oe); // R2

   AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !pp |-> (!pin && (oe == act))); // R3

   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (act && req) |=> act); // R4

   AST_NO_REQ_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && !req) |=> !act); // R5

   AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((pend & $past(evt)) == $past(evt))); // R6

   AST_UNCLEARED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr))); // R6

   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && (cnt != '0)) |=> !act); // R7

   AST_HOLD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act) |-> (cnt == $past(hold))); // R7

   AST_ZERO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && req && (cnt == '0)) |=> act); // R8

endmodule

bind irq_gen irq_gen_chk #(.NUM_SRC(NUM_SRC), .HOLD_W(HOLD_W)) i_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .pp   (cfg_pp_q),
   .hold (cfg_hold_q),
   .evt  (evt_i),
   .clr  (clr_w),
   .pend (pend_w),
   .req  (req_w),
   .act  (act_w),
   .cnt  (cnt_w),
   .pin  (irq_o),
   .oe   (irq_oe_o)
);

// File: tb/test_irq_gen.sv
module test_irq_gen;

   localparam int NS = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic [NS-1:0] evt_i = '0;
   logic          reg_wr_i = 1'b0;
   logic [1:0]    reg_sel_i = 2'd0;
   logic [DW-1:0] reg_wdata_i = '0;
   logic [DW-1:0] reg_rdata_o;
   logic          irq_o;
   logic          irq_oe_o;

   always #2 clk = ~clk;

   irq_gen #(.NUM_SRC(NS), .HOLD_W(8), .DATA_W(DW)) i_irq_gen (
      .clk, .rst_n, .tick_i, .evt_i, .reg_wr_i, .reg_sel_i,
      .reg_wdata_i, .reg_rdata_o, .irq_o, .irq_oe_o
   );

   typedef struct {
      logic          pin;
      logic          oe;
      logic          chk_rd;
      logic [DW-1:0] rd;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   logic m_pp = 1'b0, m_pol = 1'b0, m_act = 1'b0;

   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_vec++;
         if (irq_o !== e.pin || irq_oe_o !== e.oe) begin
            n_bad++;
            $display("FAIL %s: pin/oe got %b/%b expected %b/%b",
                     e.tag, irq_o, irq_oe_o, e.pin, e.oe);
         end
         if (e.chk_rd && reg_rdata_o !== e.rd) begin
            n_bad++;
            $display("FAIL %s: rdata got %h expected %h", e.tag, reg_rdata_o, e.rd);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic rd_on, input logic [DW-1:0] rd, input string tag);
      exp_t e;
      e.pin    = m_pp ? (m_pol ? m_act : ~m_act) : 1'b0;
      e.oe     = m_pp ? 1'b1 : m_act;
      e.chk_rd = rd_on;
      e.rd     = rd;
      e.tag    = tag;
      q.push_back(e);
   endtask

   task automatic exp_line(input string tag);
      push(1'b0, '0, tag);
   endtask

   task automatic exp_rd(input logic [1:0] sel, input logic [DW-1:0] v, input string tag);
      reg_sel_i = sel;
      push(1'b1, v, tag);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
      reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
      cyc();
      reg_wr_i = 1'b0;
   endtask

   task automatic pulse(input logic [NS-1:0] v);
      evt_i = v;
      cyc();
      evt_i = '0;
   endtask

   task automatic tick();
      tick_i = 1'b1;
      cyc();
      tick_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      // R9: reset state
      exp_rd(2'd0, 32'h0, "R9 cfg");
      cyc();
      exp_rd(2'd2, 32'h0, "R9 pend");
      cyc();
      exp_rd(2'd1, 32'h0, "R9 mask");
      // R2: push-pull, active high, no holdoff
      wr(2'd0, 32'h0000_0003); m_pp = 1; m_pol = 1;
      exp_line("R2 pp idle");
      wr(2'd1, 32'h1);
      exp_rd(2'd1, 32'h1, "R5 mask readback");
      // R4: latency and stickiness
      pulse(8'h01);
      exp_line("R4 one edge after event");
      cyc(); m_act = 1;
      exp_line("R1 active high");
      for (int i = 0; i < 3; i++) begin cyc(); exp_line("R4 held"); end
      pulse(8'h02);
      exp_rd(2'd2, 32'h3, "R6 pend readback");
      // R6: W1C clears only bit 0
      wr(2'd2, 32'h1);
      exp_line("R4 still active at clear edge");
      cyc(); m_act = 0;
      exp_line("R6 dropped after clear");
      exp_rd(2'd2, 32'h2, "R6 bit1 kept");
      for (int i = 0; i < 3; i++) begin cyc(); exp_line("R5 masked bit ignored"); end
      wr(2'd1, 32'h3);
      exp_line("R5 enable edge");
      cyc(); m_act = 1;
      exp_line("R5 enabled bit raises");
      // R8: zero holdoff rearm
      wr(2'd2, 32'h2);
      exp_line("R8 before drop");
      pulse(8'h01); m_act = 0;
      exp_line("R8 drop");
      cyc(); m_act = 1;
      exp_line("R8 immediate rearm");
      // R1: active low
      wr(2'd0, 32'h0000_0002); m_pol = 0;
      exp_line("R1 active low asserted");
      wr(2'd2, 32'hFF);
      exp_line("R1 clear edge");
      cyc(); m_act = 0;
      exp_line("R1 active low idle");
      // R7: holdoff of 3 ticks
      wr(2'd0, 32'h0300_0003); m_pol = 1;
      exp_rd(2'd0, 32'h0300_0003, "R7 cfg readback");
      pulse(8'h01);
      cyc(); m_act = 1;
      exp_line("R7 asserted");
      wr(2'd2, 32'h1);
      exp_line("R7 clear edge");
      pulse(8'h01); m_act = 0;
      exp_line("R7 dropped");
      for (int i = 0; i < 6; i++) begin cyc(); exp_line("R7 blocked without ticks"); end
      tick(); exp_line("R7 tick1");
      cyc();  exp_line("R7 between ticks");
      tick(); exp_line("R7 tick2");
      tick(); exp_line("R7 tick3 edge");
      cyc(); m_act = 1;
      exp_line("R7 released");
      // R3: open-drain, polarity bit set but ignored
      wr(2'd0, 32'h0000_0001); m_pp = 0;
      exp_line("R3 od active");
      wr(2'd2, 32'h1);
      exp_line("R3 clear edge");
      cyc(); m_act = 0;
      exp_line("R3 od released");
      // R6: set wins over simultaneous clear
      wr(2'd1, 32'h0);
      evt_i = 8'h04;
      wr(2'd2, 32'h4);
      evt_i = '0;
      exp_rd(2'd2, 32'h4, "R6 set wins");
      cyc();
      exp_line("R5 masked stays idle");
      wr(2'd2, 32'h4);
      exp_rd(2'd2, 32'h0, "R6 cleared");
      cyc(); cyc();
      finish_run();
   end

endmodule